// File: doc/BRIEF.md
# Power-Good Supervisor with Turn-On Delay and Transition Blanking

This block decides, once per clock, whether a voltage regulator's output may be reported as good. It takes the digital results of the over-limit and under-limit window comparators, an enable, a flag that reports the no-CPU voltage code, a flag showing that soft-start has reached the DAC target, and a one-cycle pulse on each dynamic voltage-code change. A free-running microsecond tick paces every timer. A 3-bit code selects the turn-on delay. The output is an active-high power-good level.

After enable rises, power-good stays low until soft-start reaches the target. A turn-on delay then starts and must expire. From then on, power-good follows the window comparators. The comparator flags are synchronized to the clock before use. Each voltage-code change opens a blanking window during which window faults are ignored. Enable low and the no-CPU code always force power-good low, with or without blanking. Enable low also discards any progress of the turn-on delay.

Top module: `pgood_supervisor`

## Requirements
- R1: While reset is asserted, and in the first clock after its synchronized release, `pgood_o` is 0.
- R2: If `en_i` is 0 at a rising clock edge, `pgood_o` is 0 after that edge.
- R3: If `nocpu_i` is 1 at a rising clock edge, `pgood_o` is 0 after that edge.
- R4: Outside blanking, a 1 on `win_hi_i` or `win_lo_i` passes through two synchronizer flops, and `pgood_o` goes low at the third rising edge after the flag is applied.
- R5: After enable, `pgood_o` stays 0 until `ss_done_i` is seen high and the turn-on delay that starts at that edge has fully elapsed.
- R6: A pulse on `dvid_i` loads a blanking window of BLANK_US ticks. While the window is open, window faults do not lower `pgood_o`.
- R7: A `dvid_i` pulse that arrives while a window is open restarts the window at the full BLANK_US ticks.
- R8: Blanking never masks `en_i` low or `nocpu_i` high.
- R9: `en_i` low clears the turn-on delay state, so the next startup waits for the full delay again.
- R10: Turn-on code c (0..7) gives a delay of (c+1)*STEP_US ticks. The code is captured at the edge where `ss_done_i` is first seen. With a tick on every cycle, `pgood_o` rises at the (c+1)*STEP_US+2-th falling edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| nocpu_i | input | 1 | Voltage code is the no-CPU value |
| ss_done_i | input | 1 | Soft-start has reached the DAC level |
| dvid_i | input | 1 | One-cycle pulse on a dynamic voltage-code change |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| ton_code_i | input | CODE_W | Turn-on delay code |
| win_hi_i | input | 1 | Output is above the high limit (asynchronous) |
| win_lo_i | input | 1 | Output is below the low limit (asynchronous) |
| pgood_o | output | 1 | Power-good, active high |

## Verification
Directed startups with codes 0 and 7 measure the exact edge at which power-good rises. This separates a correct delay length from one tick early or late, and it shows whether a dropped enable really restarts the delay. A directed blanking sequence holds a fault across two voltage-code pulses. It separates a restarted window from one that keeps its first expiry, and it then drops enable inside the window to show that blanking does not mask it. Long random runs, with a tick on every cycle or every third cycle, mix rare faults, enable drops, no-CPU codes and code changes. These runs tell apart the order in which the force conditions, the synchronizer latency and the blanking decrement interact.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Turn-on sequencing phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // disabled or waiting for soft-start to reach target
    PH_DELAY = 2'd1,  // turn-on delay counting
    PH_UP    = 2'd2   // delay expired, window decides
  } ph_e;

endpackage

// File: rtl/pg_rst_sync.sv
module pg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];

endmodule

// File: rtl/pg_flag_sync.sv
module pg_flag_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pg_turnon.sv
module pg_turnon
  import pg_pkg::*;
#(
  parameter int STEP_US = 500,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ss_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              up_o
);

  localparam int MAX_TICKS = (2 ** CODE_W) * STEP_US;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP_US);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  ph_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ld_val;

  assign ld_val = CNT_W'({1'b0, code_i} + 1'b1) * STEP_C;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          if (ss_i) begin
            st_d  = PH_DELAY;
            cnt_d = ld_val;
          end
        end
        PH_DELAY: begin
          if (tick_i) begin
            if (cnt_q == ONE_C) begin
              st_d  = PH_UP;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q - ONE_C;
            end
          end
        end
        PH_UP:   st_d = PH_UP;
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign up_o = (st_q == PH_UP);

  AST_DELAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_DELAY) |-> (cnt_q != '0)); // R5
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == PH_IDLE)); // R9
  AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && en_i) |=> up_o); // R5

endmodule

// File: rtl/pg_blank.sv
module pg_blank #(
  parameter int BLANK_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dvid_i,
  input  logic tick_i,
  output logic blank_o
);

  localparam int BW = $clog2(BLANK_US + 1);
  localparam logic [BW-1:0] BLANK_C = BW'(BLANK_US);
  localparam logic [BW-1:0] ONE_C   = BW'(1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          dec_en;

  assign dec_en = tick_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (dvid_i)      cnt_d = BLANK_C;
    else if (dec_en) cnt_d = cnt_q - ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign blank_o = (cnt_q != '0);

  AST_BLANK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dvid_i |=> (cnt_q == BLANK_C)); // R7
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !dvid_i) |=> $stable(cnt_q)); // R6
  AST_BLANK_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_o && !dvid_i) |=> !blank_o); // R6

endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import pg_pkg::*;
#(
  parameter int STEP_US  = 500,
  parameter int BLANK_US = 100,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              nocpu_i,
  input  logic              ss_done_i,
  input  logic              dvid_i,
  input  logic              us_tick_i,
  input  logic [CODE_W-1:0] ton_code_i,
  input  logic              win_hi_i,
  input  logic              win_lo_i,
  output logic              pgood_o
);

  localparam int NFLAG = 2;

  logic             rst_int_n;
  logic [NFLAG-1:0] flag_s;
  logic             fault_s;
  logic             up;
  logic             blank;
  logic             pg_q, pg_d;

  pg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  pg_flag_sync #(.W(NFLAG), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({win_hi_i, win_lo_i}),
    .q_o   (flag_s)
  );

  pg_turnon #(.STEP_US(STEP_US), .CODE_W(CODE_W)) u_ton (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (en_i),
    .ss_i   (ss_done_i),
    .tick_i (us_tick_i),
    .code_i (ton_code_i),
    .up_o   (up)
  );

  pg_blank #(.BLANK_US(BLANK_US)) u_blank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dvid_i  (dvid_i),
    .tick_i  (us_tick_i),
    .blank_o (blank)
  );

  assign fault_s = |flag_s;

  always_comb begin
    pg_d = en_i && !nocpu_i && up && (!fault_s || blank);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pg_q <= 1'b0;
    else            pg_q <= pg_d;
  end

  assign pgood_o = pg_q;

  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |=> !pgood_o); // R2
  AST_NOCPU_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    nocpu_i |=> !pgood_o); // R3
  AST_NOT_UP_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    !up |=> !pgood_o); // R5
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fault_s && !blank) |=> !pgood_o); // R4
  AST_BLANK_FORCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (blank && (!en_i || nocpu_i)) |=> !pgood_o); // R8

endmodule

// File: tb/sim_pgood_supervisor.sv
module sim_pgood_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 8;
  localparam int BLANK      = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, nocpu, ss, dvid, tick, hi, lo;
  logic [2:0] code;
  logic       pgood;

  int total = 0;
  int bad   = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgood_supervisor #(.STEP_US(STEP), .BLANK_US(BLANK), .CODE_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .nocpu_i(nocpu), .ss_done_i(ss),
    .dvid_i(dvid), .us_tick_i(tick), .ton_code_i(code),
    .win_hi_i(hi), .win_lo_i(lo), .pgood_o(pgood)
  );

  // Reference model built from the requirements
  logic  mr1, mr2, ms1, ms2, m_pg;
  int    mph, mcnt, mbc;
  string m_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {mr1, mr2} <= 2'b00;
    else        {mr1, mr2} <= {1'b1, mr1};
  end

  always_ff @(posedge clk or negedge mr2) begin
    if (!mr2) begin
      ms1 <= 0; ms2 <= 0; mph <= 0; mcnt <= 0; mbc <= 0; m_pg <= 0; m_tag <= "R1";
    end else begin
      ms1 <= hi | lo;
      ms2 <= ms1;
      if (!en) mph <= 0;
      else if (mph == 0 && ss) begin
        mph  <= 1;
        mcnt <= (int'(code) + 1) * STEP;  // R10 code to delay
      end else if (mph == 1 && tick) begin
        if (mcnt == 1) mph <= 2;
        else           mcnt <= mcnt - 1;
      end
      if (dvid)                  mbc <= BLANK;
      else if (tick && mbc != 0) mbc <= mbc - 1;
      m_pg <= en && !nocpu && (mph == 2) && (!ms2 || mbc != 0);
      if (!en)                    m_tag <= "R2";
      else if (nocpu)             m_tag <= "R3";
      else if (mph != 2)          m_tag <= "R5";
      else if (ms2 && mbc != 0)   m_tag <= "R6";
      else if (ms2)               m_tag <= "R4";
      else                        m_tag <= "R5";
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pgood=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    tick = (tick_cnt == 0);
    tick_cnt = (tick_cnt + 1) % tick_div;
    @(posedge clk);
    @(negedge clk);
    check(m_tag, pgood, m_pg);
    dvid = 0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Measure falling edges from the ss_done edge until pgood rises
  task automatic measure(input logic [2:0] c, input string tag);
    int n = 0;
    int exp_n = (int'(c) + 1) * STEP + 2;
    en = 0; ss = 0; hi = 0; lo = 0; nocpu = 0; code = c;
    quiet(3);
    en = 1;
    quiet(2);
    ss = 1;
    step();
    n = 1;
    while (!pgood && n < 1000) begin step(); n++; end
    total++;
    if (n != exp_n) begin
      bad++;
      $display("FAIL %s: rise after %0d edges expected=%0d", tag, n, exp_n);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; en = 0; nocpu = 0; ss = 0; dvid = 0; tick = 0; hi = 0; lo = 0; code = 3'd1;
    quiet(3);
    check("R1", pgood, 1'b0);
    rst_n = 1;
    quiet(1);
    check("R1", pgood, 1'b0);

    tick_div = 1; tick_cnt = 0;
    measure(3'd7, "R10");
    // R9: drop enable then start again, full delay of the new code again
    measure(3'd0, "R9");
    measure(3'd7, "R5");

    // R7: restart of blanking with a fault held across both pulses
    dvid = 1; hi = 1;
    step();
    quiet(BLANK - 6);
    dvid = 1;
    step();
    quiet(8);
    check("R7", pgood, 1'b1);
    quiet(BLANK);
    check("R6", pgood, 1'b0);
    hi = 0;
    quiet(4);
    check("R4", pgood, 1'b1);
    // R8: enable low inside a blanking window still drops pgood
    dvid = 1; lo = 1;
    step();
    en = 0;
    step();
    check("R8", pgood, 1'b0);
    en = 1; lo = 0;
    ss = 1;
    quiet(3);
    // R3 inside blanking
    measure(3'd1, "R5");
    dvid = 1; nocpu = 1;
    step();
    check("R3", pgood, 1'b0);
    nocpu = 0;
    quiet(2);

    // Constrained random mix
    for (int seg = 0; seg < 8; seg++) begin
      tick_div = (seg % 2 == 0) ? 1 : 3;
      tick_cnt = 0;
      for (int i = 0; i < 2500; i++) begin
        en    = ($urandom % 400) != 0;
        nocpu = ($urandom % 300) == 0;
        ss    = ($urandom % 4) != 0;
        dvid  = ($urandom % 120) == 0;
        hi    = ($urandom % 50) == 0;
        lo    = ($urandom % 70) == 0;
        if ($urandom % 200 == 0) code = 3'($urandom % 8);
        step();
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule